// File: doc/BRIEF.md
# High-Speed Serial Port Core

This block is a fixed-format asynchronous serial port (8 data bits, no parity, one stop bit, least significant bit first) behind a small synchronous 32-bit register port. A processor writes bytes into a 64-entry transmit queue and reads received bytes from a 64-entry receive queue. Every received word carries status flags for that byte. All line timing comes from one programmable prescaler followed by a fixed 14-tick bit period.

Interrupt causes are kept in a status register. The edge-type causes stay latched until software writes ones to them. The level-type causes follow the queue state. A single interrupt line combines each cause with its enable. The receiver can detect a line held in break, and it reports framing errors and queue overruns. The transmitter can be forced to hold the line low.

Top module: `ser_hsport`

## Requirements
- R1: After reset the rate register reads 0xFF, control reads 0x0000_2800 (sample offset 20, all else 0), level and status read 0, `irq` is 0 and `ser_tx` is high.
- R2: Registers are word addressed: 0x00 data, 0x04 level, 0x08 status, 0x0C control (22 bits kept, read back as written), 0x10 rate (8 bits). Read data appears on `bus_rdata` the cycle after `bus_rd`. Writing the rate register restarts the prescaler.
- R3: One bit lasts (rate+1)×14 clocks. The line idles high, and frames are start(0), 8 data bits LSB first, stop(1). The receiver samples each bit at tick (control[14:9] mod 14).
- R4: A data read returns the byte in [7:0], a framing error flag in [9] and a break flag in [10], and removes that entry. When the receive queue is empty the read returns 0x100 and changes nothing.
- R5: The level register holds the transmit fill in [15:8] and the receive fill in [7:0].
- R6: A data write while the transmit queue holds 64 entries is dropped.
- R7: Status bit 0 latches when the transmit fill falls from above to at or below the level chosen by control[1:0] (0→0, 1→4, 2→8, 3→16). Writing 1 to status bit 0, 3, 4 or 5 clears that bit. Status bit 6 reads as bit 0 AND the transmit enable, control[5].
- R8: Status bit 1 is high while the receive fill is at least the level chosen by control[4:2] (0→1, 1→4, 2→8, 3→16, 4→32, other→48).
- R9: With control[17:16] = n ≠ 0, status bit 2 rises once the receive queue has been non-empty with the receiver idle and no push or pop for 2^(n+1)×10 bit times. Emptying the queue drops the bit.
- R10: A character whose stop bit samples low, with some data bit high, is stored with flag [9] set and latches status bit 3.
- R11: A character whose start, data and stop samples are all low stores one entry 0x400 and latches status bit 4. No further entry is made until the line returns high.
- R12: A byte received while the receive queue is full is discarded and latches status bit 5. The stored entries are kept.
- R13: Control bit 8 drives `ser_tx` low from the next cycle for as long as it is set.
- R14: `irq` is registered. It is (st0 & ctl5) | ((st1|st2) & ctl6) | ((st3|st4|st5) & ctl7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted queue pointer or fill count shows up as a wrong byte or a wrong level value on the next data or level read. A receiver that samples at the wrong tick or counts the wrong number of ticks garbles the first looped-back character, one character time after the write. A wrong latch or clear in the status logic is seen on the next status read, and on `irq` one cycle after the cause changes. A break or framing fault decoded wrongly is seen in the flags of the single entry it produces.

// File: rtl/ser_hsport_pkg.sv
package ser_hsport_pkg;

  // word index of each register (byte address bits 4:2)
  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_LEVEL = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_CTRL  = 3'd3;
  localparam logic [2:0] A_RATE  = 3'd4;

  // status bit positions
  localparam int S_TXREQ = 0;
  localparam int S_RXTRG = 1;
  localparam int S_RXTMO = 2;
  localparam int S_FRERR = 3;
  localparam int S_BRK   = 4;
  localparam int S_OVR   = 5;
  localparam int S_TXACT = 6;

  // control field positions
  localparam int C_TXIE = 5;
  localparam int C_RXIE = 6;
  localparam int C_ERIE = 7;
  localparam int C_BRK  = 8;
  localparam int C_OFFL = 9;
  localparam int C_TMOL = 16;
  localparam int CTRL_W = 22;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(20) << C_OFFL;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic [7:0] data;
  } rx_word_t;

  function automatic int unsigned tx_trig_lvl(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int unsigned rx_trig_lvl(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction

endpackage

// File: rtl/ser_hsport_fifo.sv
module ser_hsport_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign rdata   = mem[rp];

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ser_hsport_txeng.sv
module ser_hsport_txeng #(
  parameter int OVS = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       have,
  input  logic [7:0] din,
  input  logic       brk_force,
  output logic       pop,
  output logic       txd
);
  localparam int TW = $clog2(OVS);

  logic          active;
  logic [TW-1:0] tcnt;
  logic [3:0]    bidx;
  logic [9:0]    sh;

  assign pop = tick && !active && have;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      tcnt   <= '0;
      bidx   <= '0;
      sh     <= '1;
      txd    <= 1'b1;
    end else begin
      if (tick) begin
        if (!active && have) begin
          sh     <= {1'b1, din, 1'b0};
          active <= 1'b1;
          tcnt   <= '0;
          bidx   <= '0;
        end else if (active) begin
          if (tcnt == TW'(OVS-1)) begin
            tcnt <= '0;
            sh   <= {1'b1, sh[9:1]};
            if (bidx == 4'd9) active <= 1'b0;
            else              bidx   <= bidx + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      end
      txd <= brk_force ? 1'b0 : (active ? sh[0] : 1'b1);
    end
  end
endmodule

// File: rtl/ser_hsport_rxeng.sv
module ser_hsport_rxeng
  import ser_hsport_pkg::*;
#(
  parameter int OVS = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       rxd,
  input  logic [$clog2(OVS)-1:0]     samp,
  output logic                       push,
  output rx_word_t                   word,
  output logic                       busy
);
  localparam int TW = $clog2(OVS);

  typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_WAITHI} rx_st_t;
  rx_st_t        st;
  logic [TW-1:0] tcnt;
  logic [3:0]    bidx;
  logic [7:0]    sh;
  logic          allz;

  assign busy = (st != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
      allz <= 1'b1;
      push <= 1'b0;
      word <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!rxd) begin
            st   <= RX_RUN;
            tcnt <= TW'(1);
            bidx <= '0;
            allz <= 1'b1;
          end
          RX_RUN: begin
            if (tcnt == TW'(OVS-1)) begin
              tcnt <= '0;
              bidx <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
            if (tcnt == samp) begin
              if (bidx == 4'd0) begin
                if (rxd) st <= RX_IDLE;            // false start
              end else if (bidx <= 4'd8) begin
                sh   <= {rxd, sh[7:1]};
                allz <= allz && !rxd;
              end else begin                       // stop bit
                push      <= 1'b1;
                word.data <= sh;
                word.fe   <= !rxd && !allz;
                word.brk  <= !rxd && allz;
                st        <= rxd ? RX_IDLE : RX_WAITHI;
              end
            end
          end
          default: if (rxd) st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_hsport.sv
module ser_hsport
  import ser_hsport_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int OVS    = 14,
  parameter int RATE_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ser_rx,
  output logic        ser_tx,
  output logic        irq
);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int TW  = $clog2(OVS);
  localparam int TOW = $clog2(16*10*OVS+1);
  localparam int RXW = $bits(rx_word_t);

  // ---------------- register decode
  logic       aligned;
  logic       wr_data, wr_stat, wr_ctrl, wr_rate, rd_data;
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_data = bus_wr && aligned && bus_addr[4:2] == A_DATA;
  assign wr_stat = bus_wr && aligned && bus_addr[4:2] == A_STAT;
  assign wr_ctrl = bus_wr && aligned && bus_addr[4:2] == A_CTRL;
  assign wr_rate = bus_wr && aligned && bus_addr[4:2] == A_RATE;
  assign rd_data = bus_rd && aligned && bus_addr[4:2] == A_DATA;

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata[31:CTRL_W];

  logic [CTRL_W-1:0] ctrl_q;
  logic [RATE_W-1:0] rate_q;

  // ---------------- prescaler
  logic [RATE_W-1:0] pcnt;
  logic              tick;
  assign tick = (pcnt == rate_q);

  always_ff @(posedge clk) begin
    if (rst)                  pcnt <= '0;
    else if (tick || wr_rate) pcnt <= '0;
    else                      pcnt <= pcnt + 1'b1;
  end

  // ---------------- rx synchronizer
  logic [1:0] rx_sync;
  always_ff @(posedge clk) begin
    if (rst) rx_sync <= 2'b11;
    else     rx_sync <= {rx_sync[0], ser_rx};
  end

  // ---------------- transmit path
  logic [7:0]    tx_head;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_empty, tx_pop;

  ser_hsport_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(wr_data), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty));

  ser_hsport_txeng #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .have(!tx_empty), .din(tx_head),
    .brk_force(ctrl_q[C_BRK]), .pop(tx_pop), .txd(ser_tx));

  // ---------------- receive path
  function automatic logic [TW-1:0] samp_of(input logic [5:0] off);
    int v;
    v = int'(off);
    for (int i = 0; i < 8; i++) if (v >= OVS) v = v - OVS;
    return TW'(v);
  endfunction

  logic          rx_push, rx_busy, rx_full, rx_empty, rx_pop, rx_take;
  rx_word_t      rx_in, rx_head;
  logic [CW-1:0] rx_cnt;

  ser_hsport_rxeng #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rx_sync[1]),
    .samp(samp_of(ctrl_q[C_OFFL +: 6])),
    .push(rx_push), .word(rx_in), .busy(rx_busy));

  assign rx_pop  = rd_data && !rx_empty;
  assign rx_take = rx_push && !rx_full;

  ser_hsport_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_in),
    .pop(rx_pop), .rdata(rx_head), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty));

  // ---------------- receive timeout
  logic [1:0]     to_sel;
  logic [TOW-1:0] to_cnt, to_thr;
  logic           to_flag;
  assign to_sel = ctrl_q[C_TMOL +: 2];

  always_comb begin
    case (to_sel)
      2'd1:    to_thr = TOW'(4*10*OVS);
      2'd2:    to_thr = TOW'(8*10*OVS);
      default: to_thr = TOW'(16*10*OVS);
    endcase
  end

  assign to_flag = (to_sel != 2'd0) && !rx_empty && (to_cnt >= to_thr);

  always_ff @(posedge clk) begin
    if (rst) to_cnt <= '0;
    else if (to_sel == 2'd0 || rx_busy || rx_push || rx_pop || rx_empty)
      to_cnt <= '0;
    else if (tick && to_cnt < to_thr)
      to_cnt <= to_cnt + 1'b1;
  end

  // ---------------- status latches
  logic st_txreq, st_fe, st_brk, st_ovr;
  logic tx_cond, tx_cond_q, rx_trg;
  logic set_txreq, set_fe, set_brk, set_ovr;

  assign tx_cond   = int'(tx_cnt) <= tx_trig_lvl(ctrl_q[1:0]);
  assign rx_trg    = int'(rx_cnt) >= rx_trig_lvl(ctrl_q[4:2]);
  assign set_txreq = tx_cond && !tx_cond_q;
  assign set_fe    = rx_take && rx_in.fe;
  assign set_brk   = rx_take && rx_in.brk;
  assign set_ovr   = rx_push && rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_cond_q <= 1'b1;
      st_txreq  <= 1'b0;
      st_fe     <= 1'b0;
      st_brk    <= 1'b0;
      st_ovr    <= 1'b0;
    end else begin
      tx_cond_q <= tx_cond;
      st_txreq  <= set_txreq || (st_txreq && !(wr_stat && bus_wdata[S_TXREQ]));
      st_fe     <= set_fe    || (st_fe    && !(wr_stat && bus_wdata[S_FRERR]));
      st_brk    <= set_brk   || (st_brk   && !(wr_stat && bus_wdata[S_BRK]));
      st_ovr    <= set_ovr   || (st_ovr   && !(wr_stat && bus_wdata[S_OVR]));
    end
  end

  logic [6:0] status;
  always_comb begin
    status          = '0;
    status[S_TXREQ] = st_txreq;
    status[S_RXTRG] = rx_trg;
    status[S_RXTMO] = to_flag;
    status[S_FRERR] = st_fe;
    status[S_BRK]   = st_brk;
    status[S_OVR]   = st_ovr;
    status[S_TXACT] = st_txreq && ctrl_q[C_TXIE];
  end

  // ---------------- config registers, read mux, interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RST;
      rate_q    <= '1;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_rate) rate_q <= bus_wdata[RATE_W-1:0];
      irq <= (status[S_TXREQ] && ctrl_q[C_TXIE])
          || ((status[S_RXTRG] || status[S_RXTMO]) && ctrl_q[C_RXIE])
          || ((status[S_FRERR] || status[S_BRK] || status[S_OVR]) && ctrl_q[C_ERIE]);
      if (bus_rd) begin
        bus_rdata <= '0;
        if (aligned) begin
          case (bus_addr[4:2])
            A_DATA:  bus_rdata <= rx_empty ? 32'h100
                                : {21'b0, rx_head.brk, rx_head.fe, 1'b0, rx_head.data};
            A_LEVEL: bus_rdata <= {16'b0, 8'(tx_cnt), 8'(rx_cnt)};
            A_STAT:  bus_rdata <= 32'(status);
            A_CTRL:  bus_rdata <= 32'(ctrl_q);
            A_RATE:  bus_rdata <= 32'(rate_q);
            default: bus_rdata <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ser_hsport_chk.sv
module ser_hsport_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          brk_ctl,
  input logic          ser_tx,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          tx_full,
  input logic          wr_data,
  input logic          tx_pop,
  input logic          rd_data,
  input logic          rx_empty,
  input logic [31:0]   bus_rdata,
  input logic          wr_stat,
  input logic          clr_fe_bit,
  input logic          set_fe,
  input logic          st_fe,
  input logic [2:0]    ien,
  input logic          irq
);
  // R13
  brk_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    brk_ctl |=> !ser_tx);

  // R12
  rx_fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(DEPTH));

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_data && tx_full && !tx_pop) |=> $stable(tx_cnt));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_empty) |=> bus_rdata[8]);

  // R7
  w1c_fe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && clr_fe_bit && !set_fe) |=> !st_fe);

  // R14
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (ien == 3'b000 && $past(ien) == 3'b000) |-> !irq);
endmodule

bind ser_hsport ser_hsport_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .brk_ctl(ctrl_q[8]), .ser_tx(ser_tx),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .tx_full(tx_full), .wr_data(wr_data),
  .tx_pop(tx_pop), .rd_data(rd_data), .rx_empty(rx_empty),
  .bus_rdata(bus_rdata), .wr_stat(wr_stat), .clr_fe_bit(bus_wdata[3]),
  .set_fe(set_fe), .st_fe(st_fe), .ien(ctrl_q[7:5]), .irq(irq));

// File: tb/test_ser_hsport.sv
module test_ser_hsport;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_tx, irq;
  logic        loop = 1'b0, rx_drv = 1'b1;
  logic        rx_line;

  int n_chk = 0, n_fail = 0;
  logic [7:0] sent [0:66];
  logic [31:0] d;

  localparam logic [4:0] AD_DATA = 5'h00, AD_LVL = 5'h04, AD_ST = 5'h08,
                         AD_CTL = 5'h0C, AD_RATE = 5'h10;
  localparam logic [31:0] CDEF = 32'h0000_2800;

  assign rx_line = loop ? ser_tx : rx_drv;

  always #5 clk = ~clk;

  ser_hsport i_ser_hsport (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_rx(rx_line),
    .ser_tx(ser_tx), .irq(irq));

  function automatic logic [31:0] exp_word(input logic [7:0] b, input logic fe, input logic brk);
    return {21'b0, brk, fe, 1'b0, b};
  endfunction

  function automatic logic [31:0] exp_lvl(input int tx, input int rx);
    return 32'((tx << 8) | rx);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tx_drain();
    logic [31:0] v;
    do rd(AD_LVL, v); while (v[15:8] != 0);
    idle(300);
  endtask

  // drive one frame on ser_rx; bt = clocks per bit
  task automatic drive_char(input logic [7:0] b, input logic stopv, input int bt);
    @(negedge clk);
    rx_drv = 1'b0; idle(bt);
    for (int i = 0; i < 8; i++) begin rx_drv = b[i]; idle(bt); end
    rx_drv = stopv; idle(bt);
    rx_drv = 1'b1; idle(bt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset values
    chk("R1 ser_tx", 32'(ser_tx), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    rd(AD_RATE, d); chk("R1 rate", d, 32'hFF);
    rd(AD_CTL, d);  chk("R1 ctrl", d, CDEF);
    rd(AD_LVL, d);  chk("R1 level", d, 32'd0);
    rd(AD_ST, d);   chk("R1 status", d, 32'd0);

    // R2 readback of control storage bits
    wr(AD_CTL, CDEF | 32'h0038_8000);
    rd(AD_CTL, d);  chk("R2 ctrl readback", d, CDEF | 32'h0038_8000);
    wr(AD_CTL, CDEF);

    // R6/R5: fill the transmit queue before the slow prescaler ticks
    wr(AD_RATE, 32'hFF);
    for (int i = 0; i < 66; i++) wr(AD_DATA, 32'(i));
    rd(AD_LVL, d);  chk("R6 full drop level", d, exp_lvl(64, 0));
    rd(AD_ST, d);   chk("R7 no txreq while full", d & 32'h1, 32'h0);
    wr(AD_RATE, 32'h00);
    rd(AD_RATE, d); chk("R2 rate readback", d, 32'h00);
    wait_tx_drain();
    rd(AD_ST, d);   chk("R7 txreq on empty", d & 32'h1, 32'h1);
    wr(AD_ST, 32'h1);
    rd(AD_ST, d);   chk("R7 txreq w1c", d & 32'h1, 32'h0);
    rd(AD_LVL, d);  chk("R5 rx idle level", d, 32'h0);

    // R3/R4/R8 random loopback
    loop = 1'b1;
    for (int i = 0; i < 24; i++) begin
      sent[i] = 8'($urandom);
      wr(AD_DATA, 32'(sent[i]));
    end
    wait_tx_drain();
    rd(AD_LVL, d);  chk("R5 rx level 24", d, exp_lvl(0, 24));
    rd(AD_ST, d);   chk("R8 rx trigger at 1", d & 32'h3A, 32'h02);
    wr(AD_CTL, CDEF | (32'd5 << 2));
    rd(AD_ST, d);   chk("R8 rx trigger 48 not met", d & 32'h2, 32'h0);
    wr(AD_CTL, CDEF);
    for (int i = 0; i < 24; i++) begin
      rd(AD_DATA, d); chk("R3 loopback byte", d, exp_word(sent[i], 1'b0, 1'b0));
    end
    rd(AD_DATA, d); chk("R4 empty read", d, 32'h100);
    rd(AD_DATA, d); chk("R4 empty read again", d, 32'h100);
    rd(AD_LVL, d);  chk("R4 empty read no effect", d, 32'h0);

    // R7 transmit trigger at 8
    wr(AD_CTL, CDEF | 32'd2);
    for (int i = 0; i < 20; i++) begin
      sent[i] = 8'($urandom);
      wr(AD_DATA, 32'(sent[i]));
    end
    wr(AD_ST, 32'h1);
    do rd(AD_LVL, d); while (d[15:8] > 10);
    rd(AD_ST, d);   chk("R7 above level", d & 32'h1, 32'h0);
    do rd(AD_LVL, d); while (d[15:8] > 8);
    rd(AD_ST, d);   chk("R7 at level", d & 32'h1, 32'h1);
    wr(AD_CTL, CDEF | 32'd2 | 32'h20);
    rd(AD_ST, d);   chk("R7 bit6 follows enable", d & 32'h41, 32'h41);
    idle(2);
    chk("R14 tx irq", 32'(irq), 32'd1);
    wr(AD_CTL, CDEF);
    wr(AD_ST, 32'h1);
    wait_tx_drain();
    for (int i = 0; i < 20; i++) begin
      rd(AD_DATA, d); chk("R3 loopback byte 2", d, exp_word(sent[i], 1'b0, 1'b0));
    end

    // R12 overrun
    for (int i = 0; i < 64; i++) begin
      sent[i] = 8'($urandom);
      wr(AD_DATA, 32'(sent[i]));
    end
    do rd(AD_LVL, d); while (d[15:8] > 61);
    for (int i = 64; i < 67; i++) begin
      sent[i] = 8'($urandom);
      wr(AD_DATA, 32'(sent[i]));
    end
    wait_tx_drain();
    rd(AD_LVL, d);  chk("R12 rx full", d, exp_lvl(0, 64));
    rd(AD_ST, d);   chk("R12 overrun latched", d & 32'h20, 32'h20);
    idle(2);
    chk("R14 irq masked", 32'(irq), 32'd0);
    wr(AD_CTL, CDEF | 32'h80);
    idle(2);
    chk("R14 err irq", 32'(irq), 32'd1);
    wr(AD_ST, 32'h20);
    idle(2);
    chk("R14 irq after clear", 32'(irq), 32'd0);
    rd(AD_ST, d);   chk("R7 overrun w1c", d & 32'h20, 32'h0);
    wr(AD_CTL, CDEF);
    for (int i = 0; i < 64; i++) begin
      rd(AD_DATA, d); chk("R12 kept entries", d, exp_word(sent[i], 1'b0, 1'b0));
    end

    // R10 framing error
    loop = 1'b0;
    drive_char(8'hA5, 1'b0, 14);
    idle(20);
    rd(AD_DATA, d); chk("R10 fe entry", d, exp_word(8'hA5, 1'b1, 1'b0));
    rd(AD_ST, d);   chk("R10 fe latched", d & 32'h38, 32'h08);
    wr(AD_ST, 32'h08);
    rd(AD_ST, d);   chk("R7 fe w1c", d & 32'h08, 32'h0);

    // R11 break
    @(negedge clk); rx_drv = 1'b0; idle(14 * 14);
    rx_drv = 1'b1; idle(40);
    rd(AD_LVL, d);  chk("R11 single entry", d, exp_lvl(0, 1));
    rd(AD_DATA, d); chk("R11 break entry", d, 32'h400);
    rd(AD_ST, d);   chk("R11 break latched", d & 32'h38, 32'h10);
    wr(AD_ST, 32'h10);

    // R13 break generation
    wr(AD_CTL, CDEF | 32'h100);
    idle(2);
    chk("R13 tx forced low", 32'(ser_tx), 32'd0);
    wr(AD_CTL, CDEF);
    idle(2);
    chk("R13 tx released", 32'(ser_tx), 32'd1);

    // R9 timeout, rx trigger set to 48 so bit1 stays low
    wr(AD_CTL, CDEF | 32'h0001_0000 | (32'd5 << 2) | 32'h40);
    drive_char(8'h3C, 1'b1, 14);
    rd(AD_ST, d);   chk("R9 no early timeout", d & 32'h6, 32'h0);
    idle(2);
    chk("R14 rx irq idle", 32'(irq), 32'd0);
    idle(700);
    rd(AD_ST, d);   chk("R9 timeout set", d & 32'h6, 32'h4);
    idle(2);
    chk("R14 rx irq timeout", 32'(irq), 32'd1);
    rd(AD_DATA, d); chk("R9 byte", d, exp_word(8'h3C, 1'b0, 1'b0));
    rd(AD_ST, d);   chk("R9 timeout clears", d & 32'h4, 32'h0);

    // R3 sample offset and rate
    wr(AD_CTL, CDEF | (32'h3F << 9) & 32'h7E00 | (32'h3F << 9));
    drive_char(8'h96, 1'b1, 14);
    rd(AD_DATA, d); chk("R3 offset 63", d, exp_word(8'h96, 1'b0, 1'b0));
    wr(AD_CTL, 32'h0);
    drive_char(8'h5A, 1'b1, 14);
    rd(AD_DATA, d); chk("R3 offset 0", d, exp_word(8'h5A, 1'b0, 1'b0));
    wr(AD_CTL, CDEF);
    wr(AD_RATE, 32'h01);
    drive_char(8'hC3, 1'b1, 28);
    rd(AD_DATA, d); chk("R3 rate 1 bit time", d, exp_word(8'hC3, 1'b0, 1'b0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule